// File: doc/BRIEF.md
# Multi-cycle control sequencer

This block is the control unit of a multi-cycle processor datapath in which one ALU, one memory port and a set of holding registers are reused across several clock cycles per instruction. It is a Moore state machine. Every instruction goes through a shared fetch state and then a shared decode/register-read state. After decode the machine follows a path that depends on the instruction class. Register-register operations take four cycles, loads take five, stores take four, and branches and jumps take three. Any opcode the machine does not recognise goes straight back to fetch after decode.

Each datapath control line is a function of the current state only: the enables for memory read and write, instruction-register load, PC load, conditional PC load and register-file write, and the selects for PC source, ALU operands, ALU operation class, destination register, write-back source and memory address source. The one exception is a combined PC load output. It merges the unconditional PC write with the conditional one, qualified by the ALU zero flag, so the datapath gets a single PC enable. The opcode input is expected to come from the instruction register. The machine samples it in the decode state, and again in the address-compute state to tell a load from a store.

Top module: `mcf_ctrl`

## Requirements
- R1: While rst_n is low, mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, reg_wr and pc_load are all 0, whatever alu_zero is. In the first cycle after rst_n rises, the machine is in the fetch state. A reset asserted in the middle of an instruction abandons that instruction.
- R2: Fetch state drives mem_rd=1, addr_src=0, ir_wr=1, pc_wr=1, pc_src=00, alu_src_a=0, alu_src_b=01 and alu_op=00 (add). Every other enable is 0. The next state is always decode, whatever the opcode.
- R3: Decode state drives alu_src_a=0, alu_src_b=11 and alu_op=00, with no enable asserted. The next state is chosen from the opcode: 000000 goes to execute, 100011 or 101011 goes to address compute, 000100 goes to branch, and 000010 goes to jump.
- R4: An opcode of 000000 runs fetch, decode, execute and write-back, so 4 cycles. Execute drives alu_src_a=1, alu_src_b=00 and alu_op=10 (funct-driven). Write-back drives reg_dst=1, reg_wr=1 and mem_to_reg=0.
- R5: An opcode of 100011 runs fetch, decode, address compute, memory read and load write-back, so 5 cycles. Address compute drives alu_src_a=1, alu_src_b=10 and alu_op=00. Memory read drives mem_rd=1 and addr_src=1. Load write-back drives reg_wr=1, mem_to_reg=1 and reg_dst=0.
- R6: An opcode of 101011 runs fetch, decode, address compute and memory write, so 4 cycles. Memory write drives mem_wr=1 and addr_src=1.
- R7: An opcode of 000100 runs fetch, decode and branch, so 3 cycles. Branch drives alu_src_a=1, alu_src_b=00, alu_op=01 (subtract), pc_wr_cond=1 and pc_src=01.
- R8: An opcode of 000010 runs fetch, decode and jump, so 3 cycles. Jump drives pc_wr=1 and pc_src=10.
- R9: pc_load is 1 in fetch and jump. In the branch state it is 1 only when alu_zero is 1. In every other state it is 0.
- R10: Any opcode other than the five listed returns to fetch right after decode, so it takes 2 cycles and asserts no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | OPC_W (6) | Opcode field from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| addr_src | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| ir_wr | output | 1 | Instruction register load enable |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by zero flag |
| pc_load | output | 1 | Combined PC enable for the datapath |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_src_a | output | 1 | ALU A operand: 0 = PC, 1 = register A |
| alu_src_b | output | 2 | ALU B operand: 00 reg B, 01 constant 4, 10 sign-ext imm, 11 shifted imm |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 funct-driven |
| reg_dst | output | 1 | Destination register field: 0 = rt, 1 = rd |
| mem_to_reg | output | 1 | Write-back source: 0 = ALU result, 1 = memory data |
| reg_wr | output | 1 | Register file write enable |

## Verification
The bench goes after the places where the class-dependent paths split and join. One is the address-compute state, which must split load from store; a design that mixes them up writes memory on a load or reads it on a store. Another is that every path ends in fetch, and the bench measures each class's cycle count to catch a lost or extra state. A third is the branch state, where a PC load that ignores the zero flag would take every branch. The bench also drives unknown opcodes, which a careless dispatch would send into some class's path with a write enable raised. It asserts reset in the middle of an instruction to show that the enables drop at once and that the machine restarts from fetch.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_MRD    = 4'd3,
        ST_LDWB   = 4'd4,
        ST_MWR    = 4'd5,
        ST_EXEC   = 4'd6,
        ST_RWB    = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9
    } state_e;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'b00,
        ALU_SUB   = 2'b01,
        ALU_FUNCT = 2'b10
    } alu_cls_e;

    typedef enum logic [1:0] {
        PCS_ALU    = 2'b00,
        PCS_TARGET = 2'b01,
        PCS_JUMP   = 2'b10
    } pc_src_e;

    localparam logic [1:0] SRCB_REG   = 2'b00;
    localparam logic [1:0] SRCB_FOUR  = 2'b01;
    localparam logic [1:0] SRCB_IMM   = 2'b10;
    localparam logic [1:0] SRCB_IMMSH = 2'b11;

    typedef struct packed {
        logic     mem_rd;
        logic     mem_wr;
        logic     addr_src;
        logic     ir_wr;
        logic     pc_wr;
        logic     pc_wr_cond;
        pc_src_e  pc_src;
        logic     alu_src_a;
        logic [1:0] alu_src_b;
        alu_cls_e alu_op;
        logic     reg_dst;
        logic     mem_to_reg;
        logic     reg_wr;
    } ctrl_t;

    typedef struct packed {
        state_e state;
    } seq_t;

    localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/mcf_dispatch.sv
module mcf_dispatch
    import mcf_pkg::*;
#(
    parameter int unsigned   OPC_W    = 6,
    parameter logic [OPC_W-1:0] OP_RTYPE = 6'b000000,
    parameter logic [OPC_W-1:0] OP_LOAD  = 6'b100011,
    parameter logic [OPC_W-1:0] OP_STORE = 6'b101011,
    parameter logic [OPC_W-1:0] OP_BEQ   = 6'b000100,
    parameter logic [OPC_W-1:0] OP_JUMP  = 6'b000010
) (
    input  state_e           cur,
    input  logic [OPC_W-1:0] opcode,
    output state_e           nxt
);

    logic is_mem;

    always_comb begin
        is_mem = (opcode == OP_LOAD) || (opcode == OP_STORE);
        nxt    = ST_FETCH;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OP_RTYPE)    nxt = ST_EXEC;
                else if (is_mem)           nxt = ST_ADDR;
                else if (opcode == OP_BEQ) nxt = ST_BRANCH;
                else if (opcode == OP_JUMP) nxt = ST_JUMP;
                else                       nxt = ST_FETCH;
            end
            ST_ADDR:   nxt = (opcode == OP_STORE) ? ST_MWR : ST_MRD;
            ST_MRD:    nxt = ST_LDWB;
            ST_EXEC:   nxt = ST_RWB;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcf_outdec.sv
module mcf_outdec
    import mcf_pkg::*;
(
    input  state_e st,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl = CTRL_IDLE;
        case (st)
            ST_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_wr     = 1'b1;
                ctrl.pc_wr     = 1'b1;
                ctrl.pc_src    = PCS_ALU;
                ctrl.alu_src_b = SRCB_FOUR;
                ctrl.alu_op    = ALU_ADD;
            end
            ST_DECODE: begin
                ctrl.alu_src_b = SRCB_IMMSH;
                ctrl.alu_op    = ALU_ADD;
            end
            ST_ADDR: begin
                ctrl.alu_src_a = 1'b1;
                ctrl.alu_src_b = SRCB_IMM;
                ctrl.alu_op    = ALU_ADD;
            end
            ST_MRD: begin
                ctrl.mem_rd   = 1'b1;
                ctrl.addr_src = 1'b1;
            end
            ST_LDWB: begin
                ctrl.reg_wr     = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            ST_MWR: begin
                ctrl.mem_wr   = 1'b1;
                ctrl.addr_src = 1'b1;
            end
            ST_EXEC: begin
                ctrl.alu_src_a = 1'b1;
                ctrl.alu_src_b = SRCB_REG;
                ctrl.alu_op    = ALU_FUNCT;
            end
            ST_RWB: begin
                ctrl.reg_dst = 1'b1;
                ctrl.reg_wr  = 1'b1;
            end
            ST_BRANCH: begin
                ctrl.alu_src_a  = 1'b1;
                ctrl.alu_src_b  = SRCB_REG;
                ctrl.alu_op     = ALU_SUB;
                ctrl.pc_wr_cond = 1'b1;
                ctrl.pc_src     = PCS_TARGET;
            end
            ST_JUMP: begin
                ctrl.pc_wr  = 1'b1;
                ctrl.pc_src = PCS_JUMP;
            end
            default: ctrl = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/mcf_ctrl.sv
module mcf_ctrl
    import mcf_pkg::*;
#(
    parameter int unsigned   OPC_W    = 6,
    parameter logic [OPC_W-1:0] OP_RTYPE = 6'b000000,
    parameter logic [OPC_W-1:0] OP_LOAD  = 6'b100011,
    parameter logic [OPC_W-1:0] OP_STORE = 6'b101011,
    parameter logic [OPC_W-1:0] OP_BEQ   = 6'b000100,
    parameter logic [OPC_W-1:0] OP_JUMP  = 6'b000010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_zero,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             addr_src,
    output logic             ir_wr,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             pc_load,
    output logic [1:0]       pc_src,
    output logic             alu_src_a,
    output logic [1:0]       alu_src_b,
    output logic [1:0]       alu_op,
    output logic             reg_dst,
    output logic             mem_to_reg,
    output logic             reg_wr
);

    seq_t   seq_d, seq_q;
    state_e nxt_state;
    ctrl_t  ctrl_dec, ctrl_live;

    mcf_dispatch #(
        .OPC_W    (OPC_W),
        .OP_RTYPE (OP_RTYPE),
        .OP_LOAD  (OP_LOAD),
        .OP_STORE (OP_STORE),
        .OP_BEQ   (OP_BEQ),
        .OP_JUMP  (OP_JUMP)
    ) u_dispatch (
        .cur    (seq_q.state),
        .opcode (opcode),
        .nxt    (nxt_state)
    );

    mcf_outdec u_outdec (
        .st   (seq_q.state),
        .ctrl (ctrl_dec)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.state = nxt_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_FETCH};
        else        seq_q <= seq_d;
    end

    // Reset holds every enable low; release lands directly in fetch.
    always_comb begin
        ctrl_live = rst_n ? ctrl_dec : CTRL_IDLE;
    end

    assign mem_rd     = ctrl_live.mem_rd;
    assign mem_wr     = ctrl_live.mem_wr;
    assign addr_src   = ctrl_live.addr_src;
    assign ir_wr      = ctrl_live.ir_wr;
    assign pc_wr      = ctrl_live.pc_wr;
    assign pc_wr_cond = ctrl_live.pc_wr_cond;
    assign pc_src     = ctrl_live.pc_src;
    assign alu_src_a  = ctrl_live.alu_src_a;
    assign alu_src_b  = ctrl_live.alu_src_b;
    assign alu_op     = ctrl_live.alu_op;
    assign reg_dst    = ctrl_live.reg_dst;
    assign mem_to_reg = ctrl_live.mem_to_reg;
    assign reg_wr     = ctrl_live.reg_wr;
    assign pc_load    = ctrl_live.pc_wr | (ctrl_live.pc_wr_cond & alu_zero);

endmodule

// File: rtl/mcf_ctrl_chk.sv
module mcf_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       alu_zero,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       addr_src,
    input logic       ir_wr,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       pc_load,
    input logic [1:0] alu_src_b,
    input logic [1:0] alu_op,
    input logic       reg_dst,
    input logic       mem_to_reg,
    input logic       reg_wr
);

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert ({mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, reg_wr, pc_load} == 7'd0);
        end
    end

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> (alu_src_b == 2'b11 && !ir_wr));

    // R4
    exec_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 2'b10) |=> (reg_wr && reg_dst && !mem_to_reg));

    // R5
    load_read_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && addr_src) |=> (reg_wr && mem_to_reg && !reg_dst));

    // R6
    store_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ir_wr);

    // R7
    branch_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |=> ir_wr);

    // R9
    branch_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_cond && !alu_zero) |-> !pc_load);

    // R10
    single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, reg_wr, ir_wr, pc_wr_cond}));

endmodule

bind mcf_ctrl mcf_ctrl_chk u_mcf_ctrl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alu_zero   (alu_zero),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .addr_src   (addr_src),
    .ir_wr      (ir_wr),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .pc_load    (pc_load),
    .alu_src_b  (alu_src_b),
    .alu_op     (alu_op),
    .reg_dst    (reg_dst),
    .mem_to_reg (mem_to_reg),
    .reg_wr     (reg_wr)
);

// File: tb/tb_mcf_ctrl.sv
`timescale 1ns/1ps
module tb_mcf_ctrl;

    localparam logic [5:0] K_R  = 6'b000000;
    localparam logic [5:0] K_LW = 6'b100011;
    localparam logic [5:0] K_SW = 6'b101011;
    localparam logic [5:0] K_BQ = 6'b000100;
    localparam logic [5:0] K_J  = 6'b000010;

    localparam int S_F = 0, S_D = 1, S_A = 2, S_MR = 3, S_LW = 4,
                   S_MW = 5, S_X = 6, S_RW = 7, S_B = 8, S_J = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic alu_zero = 1'b0;
    logic mem_rd, mem_wr, addr_src, ir_wr, pc_wr, pc_wr_cond, pc_load;
    logic [1:0] pc_src, alu_src_b, alu_op;
    logic alu_src_a, reg_dst, mem_to_reg, reg_wr;

    int total = 0;
    int bad = 0;
    int st = S_F;

    always #10 clk = ~clk;

    mcf_ctrl dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_src(addr_src), .ir_wr(ir_wr),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_load(pc_load), .pc_src(pc_src),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
        .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr)
    );

    // {mem_rd,mem_wr,addr_src,ir_wr,pc_wr,pc_wr_cond,pc_src,alu_src_a,alu_src_b,alu_op,reg_dst,mem_to_reg,reg_wr}
    function automatic logic [15:0] exp_vec(int s);
        logic [15:0] v = '0;
        case (s)
            S_F:  v = {1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,2'b01,2'b00,3'b000};
            S_D:  v = {6'b0,2'b00,1'b0,2'b11,2'b00,3'b000};
            S_A:  v = {6'b0,2'b00,1'b1,2'b10,2'b00,3'b000};
            S_MR: v = {1'b1,1'b0,1'b1,3'b000,2'b00,1'b0,2'b00,2'b00,3'b000};
            S_LW: v = {6'b0,2'b00,1'b0,2'b00,2'b00,3'b011};
            S_MW: v = {1'b0,1'b1,1'b1,3'b000,2'b00,1'b0,2'b00,2'b00,3'b000};
            S_X:  v = {6'b0,2'b00,1'b1,2'b00,2'b10,3'b000};
            S_RW: v = {6'b0,2'b00,1'b0,2'b00,2'b00,3'b101};
            S_B:  v = {5'b0,1'b1,2'b01,1'b1,2'b00,2'b01,3'b000};
            S_J:  v = {4'b0,1'b1,1'b0,2'b10,1'b0,2'b00,2'b00,3'b000};
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic int exp_next(int s, logic [5:0] op);
        case (s)
            S_F: return S_D;
            S_D: begin
                if (op == K_R) return S_X;
                if (op == K_LW || op == K_SW) return S_A;
                if (op == K_BQ) return S_B;
                if (op == K_J) return S_J;
                return S_F;
            end
            S_A: return (op == K_SW) ? S_MW : S_MR;
            S_MR: return S_LW;
            S_X: return S_RW;
            default: return S_F;
        endcase
    endfunction

    function automatic string req_of(int s);
        case (s)
            S_F: return "R2";
            S_D: return "R3";
            S_X, S_RW: return "R4";
            S_A, S_MR, S_LW: return "R5";
            S_MW: return "R6";
            S_B: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check_now();
        logic [15:0] got;
        logic pl_exp;
        got = {mem_rd, mem_wr, addr_src, ir_wr, pc_wr, pc_wr_cond, pc_src,
               alu_src_a, alu_src_b, alu_op, reg_dst, mem_to_reg, reg_wr};
        total++;
        if (got !== exp_vec(st)) begin
            bad++;
            $display("FAIL %s state=%0d got=%h exp=%h", req_of(st), st, got, exp_vec(st));
        end
        // R9: combined PC enable
        pl_exp = (st == S_F) || (st == S_J) || (st == S_B && alu_zero);
        total++;
        if (pc_load !== pl_exp) begin
            bad++;
            $display("FAIL R9 state=%0d zero=%0b got=%0b exp=%0b", st, alu_zero, pc_load, pl_exp);
        end
    endtask

    task automatic check_quiet(string tag);
        logic [6:0] en;
        en = {mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, reg_wr, pc_load};
        total++;
        if (en !== 7'd0) begin
            bad++;
            $display("FAIL %s enables got=%b exp=0000000", tag, en);
        end
    endtask

    task automatic step();
        #1;
        check_now();
        st = exp_next(st, opcode);
        @(negedge clk);
    endtask

    // Count edges from a fetch until ir_wr is seen again.
    task automatic measure(logic [5:0] op, int exp_len, string tag);
        int n = 0;
        bit found = 0;
        opcode = op;
        for (int i = 0; i < 8 && !found; i++) begin
            @(negedge clk);
            n++;
            #1;
            if (ir_wr) found = 1;
        end
        total++;
        if (!found || n != exp_len) begin
            bad++;
            $display("FAIL %s op=%b cycles got=%0d exp=%0d", tag, op, n, exp_len);
        end
        st = S_F;
        @(negedge clk);
        // that edge moved the design on to decode
        st = S_D;
        step();
        while (st != S_F) step();
    endtask

    function automatic logic [5:0] pick();
        int r = $urandom % 8;
        case (r)
            0: return K_R;
            1: return K_LW;
            2: return K_SW;
            3: return K_BQ;
            4: return K_J;
            5: return 6'($urandom);
            6: return 6'b111111;
            default: return (($urandom % 2) != 0) ? K_LW : K_BQ;
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset quiet even with zero flag high
        alu_zero = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check_quiet("R1");
        @(negedge clk);
        rst_n = 1'b1;
        st = S_F;
        // R1: first cycle after release is fetch
        opcode = K_J;
        step();
        while (st != S_F) step();

        // Directed class lengths (R4 R5 R6 R7 R8 R10)
        measure(K_R,  4, "R4");
        measure(K_LW, 5, "R5");
        measure(K_SW, 4, "R6");
        measure(K_BQ, 3, "R7");
        measure(K_J,  3, "R8");
        measure(6'b111111, 2, "R10");
        measure(6'b000001, 2, "R10");

        // R9: branch with zero low then high
        opcode = K_BQ;
        step(); step();
        alu_zero = 1'b0; #1; check_now();
        alu_zero = 1'b1; #1; check_now();
        st = exp_next(st, opcode);
        @(negedge clk);

        // R1: reset in the middle of an R-type execute
        opcode = K_R;
        step(); step();
        rst_n = 1'b0;
        #1;
        check_quiet("R1");
        @(negedge clk);
        #1;
        check_quiet("R1");
        rst_n = 1'b1;
        st = S_F;
        step();

        // Random mix
        for (int c = 0; c < 4000; c++) begin
            if (st == S_F) opcode = pick();
            alu_zero = 1'($urandom);
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule